// File: doc/BRIEF.md
# Ethernet MAC DMA Control and Interrupt Register Bank

This block is the software-visible register bank of an Ethernet MAC DMA controller. A processor reaches it over a simple word-addressed read/write bus. The bank holds the descriptor-list start addresses, the run-control word, the interrupt-enable and interrupt-status words, and the current-descriptor pointers that the DMA engines advance. The transmit and receive DMA engines raise events through single-cycle pulse vectors. The bank latches those events into the status word and drives two interrupt lines. The transmit line is fed by the upper status half and the receive line by the lower half.

A software reset command returns the bank to its power-on contents after a fixed number of cycles. Until that happens, every read returns zero. Software can therefore poll a register whose reset value is non-zero to learn when the reset has finished. Writes to the transmit or receive poll words produce a one-cycle kick pulse for the matching DMA engine.

Top module: `mac_csr_bank`

## Requirements
- R1: After the synchronous reset input, reads return 0xFFFFFFFC at word 0x22 (transmit list start) and word 0x23 (receive list start), 0x00900000 at 0x26, 0x00000101 at 0x27, 0x00000800 at 0x2A and 0x00007FFF at 0x2E. Every other word, mapped or unmapped, reads 0.
- R2: The control word at 0x24 keeps only bit 8 (transmit on), bit 1 (long frames accepted) and bit 0 (receive on). The other bits read 0, and these three bits also appear on `tx_enable`, `long_frame_ok` and `rx_enable`. Words 0x25, 0x26, 0x27 and 0x2A are fully read/write.
- R3: Writing control bit 24 starts a software reset. `swr_busy` is then high for exactly SWR_CYCLES cycles, and every read issued while it is high returns 0.
- R4: When the software reset ends, every register holds its R1 value, and control bit 24 reads 0.
- R5: A pulse on `tx_evt[i]` sets status bit 16+i and a pulse on `rx_evt[i]` sets status bit i (word 0x2C). Only status bits 24, 23, 18, 16, 11, 10, 9, 8, 4, 3 and 0 exist; pulses aimed at any other bit are ignored.
- R6: Status bits are write-one-to-clear. Writing ones to the upper 16 bits clears only transmit events, and writing ones to the lower 16 bits clears only receive events. An event arriving in the same cycle as a clear wins.
- R7: `tx_irq` rises one cycle after an enabled status bit in bits 31..16 is set, and falls one cycle after no enabled bit in that half remains.
- R8: `rx_irq` behaves the same way for bits 15..0 and is not affected by the transmit half.
- R9: In the interrupt-enable word at 0x2B, only bits 18, 16, 4 and 0 are writable. All other bits read 0.
- R10: Writes to the list start words are accepted only while transmit and receive are both off. Bits 1..0 of a list start always read 0.
- R11: A control write that turns transmit (or receive) on from off loads that direction's current-descriptor pointer (0x33 transmit, 0x35 receive) from its list start. Between such loads, the pointer follows `tx_cur_we`/`rx_cur_we` from the DMA engine.
- R12: A write to word 0x28 gives a one-cycle `tx_poll` pulse and a write to word 0x29 gives a one-cycle `rx_poll` pulse. Both words read 0.
- R13: `bus_rdata` is registered: it presents the addressed word in the cycle after `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| tx_evt | input | 16 | Transmit event pulses, bit i sets status bit 16+i |
| rx_evt | input | 16 | Receive event pulses, bit i sets status bit i |
| tx_cur_we | input | 1 | Transmit DMA loads its current-descriptor pointer |
| tx_cur_val | input | 32 | Value for the transmit current-descriptor pointer |
| rx_cur_we | input | 1 | Receive DMA loads its current-descriptor pointer |
| rx_cur_val | input | 32 | Value for the receive current-descriptor pointer |
| tx_enable | output | 1 | Transmit on |
| rx_enable | output | 1 | Receive on |
| long_frame_ok | output | 1 | Long frames accepted |
| tx_list_base | output | 32 | Transmit descriptor-list start |
| rx_list_base | output | 32 | Receive descriptor-list start |
| tx_cur_ptr | output | 32 | Transmit current-descriptor pointer |
| rx_cur_ptr | output | 32 | Receive current-descriptor pointer |
| fifo_thresh | output | 32 | FIFO threshold word |
| max_frame | output | 32 | DMA maximum-frame word |
| tx_poll | output | 1 | Transmit poll kick pulse |
| rx_poll | output | 1 | Receive poll kick pulse |
| swr_busy | output | 1 | Software reset in progress |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |

## Verification
The hardest case to reach from the ports is the software-reset window. Reads have to land inside it and return zero, and the registers must then snap back to their reset values at the cycle the window closes. To get there, the bench first loads non-default values and turns transmit on. It then issues the reset command and follows it at once with back-to-back reads, which all fall inside the window. It counts how many cycles `swr_busy` stays high, and afterwards reads every register again. Interrupt timing is checked cycle by cycle: first no edge, then the rising edge, each with the enables of the opposite half set to show that the two lines stay apart.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;
  localparam int DW = 32;
  localparam int HW = DW / 2;

  // word offsets decoded by software drivers
  localparam int OFS_TX_BASE = 'h22;
  localparam int OFS_RX_BASE = 'h23;
  localparam int OFS_CTRL    = 'h24;
  localparam int OFS_MII_DAT = 'h25;
  localparam int OFS_MII_ADR = 'h26;
  localparam int OFS_FIFO_TH = 'h27;
  localparam int OFS_TX_POLL = 'h28;
  localparam int OFS_RX_POLL = 'h29;
  localparam int OFS_MAX_FR  = 'h2A;
  localparam int OFS_INT_EN  = 'h2B;
  localparam int OFS_INT_ST  = 'h2C;
  localparam int OFS_MISSED  = 'h2E;
  localparam int OFS_TX_CUR  = 'h33;
  localparam int OFS_RX_CUR  = 'h35;

  // control word bit positions
  localparam int SWR_BIT  = 24;
  localparam int TXON_BIT = 8;
  localparam int LONG_BIT = 1;
  localparam int RXON_BIT = 0;
  localparam logic [DW-1:0] CTRL_RW = (DW'(1) << TXON_BIT) | (DW'(1) << LONG_BIT)
                                    | (DW'(1) << RXON_BIT);

  // implemented status and enable bits
  localparam logic [DW-1:0] STAT_IMPL = 32'h0185_0F19;
  localparam logic [DW-1:0] EN_IMPL   = 32'h0005_0011;

  // reset values
  localparam logic [DW-1:0] RST_LIST_BASE = 32'hFFFF_FFFC;
  localparam logic [DW-1:0] RST_MII_ADR   = 32'h0090_0000;
  localparam logic [DW-1:0] RST_FIFO_TH   = 32'h0000_0101;
  localparam logic [DW-1:0] RST_MAX_FR    = 32'h0000_0800;
  localparam logic [DW-1:0] RST_MISSED    = 32'h0000_7FFF;
endpackage

// File: rtl/mac_csr_swr.sv
module mac_csr_swr #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  assign done = busy && (cnt == LAST);
endmodule

// File: rtl/mac_csr_irq_half.sv
module mac_csr_irq_half #(
  parameter int          W    = 16,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] ENM  = '1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         st_we,
  input  logic [W-1:0] st_wdata,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         irq
);
  logic [W-1:0] clr_bits;
  assign clr_bits = st_we ? st_wdata : '0;

  always_ff @(posedge clk) begin
    if (clr) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_bits) | (evt & IMPL);
      if (en_we) enable <= en_wdata & ENM;
      irq <= |(status & enable);
    end
  end
endmodule

// File: rtl/mac_csr_ptr.sv
module mac_csr_ptr #(
  parameter int           W        = 32,
  parameter logic [W-1:0] BASE_RST = '1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         base_we,
  input  logic [W-1:0] base_wdata,
  input  logic         lock,
  input  logic         reload,
  input  logic         dma_we,
  input  logic [W-1:0] dma_val,
  output logic [W-1:0] base,
  output logic [W-1:0] cur
);
  localparam logic [W-1:0] ALIGN = ~W'(3);

  always_ff @(posedge clk) begin
    if (clr) begin
      base <= BASE_RST;
      cur  <= '0;
    end else begin
      if (base_we && !lock) base <= base_wdata & ALIGN;
      if (reload)           cur  <= base;
      else if (dma_we)      cur  <= dma_val;
    end
  end
endmodule

// File: rtl/mac_csr_bank.sv
module mac_csr_bank #(
  parameter int ADDR_W     = 7,
  parameter int SWR_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       tx_evt,
  input  logic [15:0]       rx_evt,
  input  logic              tx_cur_we,
  input  logic [31:0]       tx_cur_val,
  input  logic              rx_cur_we,
  input  logic [31:0]       rx_cur_val,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              long_frame_ok,
  output logic [31:0]       tx_list_base,
  output logic [31:0]       rx_list_base,
  output logic [31:0]       tx_cur_ptr,
  output logic [31:0]       rx_cur_ptr,
  output logic [31:0]       fifo_thresh,
  output logic [31:0]       max_frame,
  output logic              tx_poll,
  output logic              rx_poll,
  output logic              swr_busy,
  output logic              tx_irq,
  output logic              rx_irq
);
  import mac_csr_pkg::*;

  // index 0 = receive direction, index 1 = transmit direction
  localparam int NDIR = 2;

  logic swr_done, clr, wr_ok, swr_start;
  logic hit_txb, hit_rxb, hit_ctrl, hit_miid, hit_miia, hit_fifo;
  logic hit_txp, hit_rxp, hit_maxf, hit_en, hit_st;

  assign wr_ok    = bus_wr && !swr_busy;
  assign hit_txb  = wr_ok && (bus_addr == ADDR_W'(OFS_TX_BASE));
  assign hit_rxb  = wr_ok && (bus_addr == ADDR_W'(OFS_RX_BASE));
  assign hit_ctrl = wr_ok && (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_miid = wr_ok && (bus_addr == ADDR_W'(OFS_MII_DAT));
  assign hit_miia = wr_ok && (bus_addr == ADDR_W'(OFS_MII_ADR));
  assign hit_fifo = wr_ok && (bus_addr == ADDR_W'(OFS_FIFO_TH));
  assign hit_txp  = wr_ok && (bus_addr == ADDR_W'(OFS_TX_POLL));
  assign hit_rxp  = wr_ok && (bus_addr == ADDR_W'(OFS_RX_POLL));
  assign hit_maxf = wr_ok && (bus_addr == ADDR_W'(OFS_MAX_FR));
  assign hit_en   = wr_ok && (bus_addr == ADDR_W'(OFS_INT_EN));
  assign hit_st   = wr_ok && (bus_addr == ADDR_W'(OFS_INT_ST));

  assign swr_start = hit_ctrl && bus_wdata[SWR_BIT];

  mac_csr_swr #(.CYCLES(SWR_CYCLES)) u_swr (
    .clk   (clk),
    .rst   (rst),
    .start (swr_start),
    .busy  (swr_busy),
    .done  (swr_done)
  );

  assign clr = rst | swr_done;

  // control word
  logic [DW-1:0] ctrl_q;
  logic          ctrl_wr;
  assign ctrl_wr = hit_ctrl && !bus_wdata[SWR_BIT];

  always_ff @(posedge clk) begin
    if (clr)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_RW;
  end

  assign tx_enable     = ctrl_q[TXON_BIT];
  assign rx_enable     = ctrl_q[RXON_BIT];
  assign long_frame_ok = ctrl_q[LONG_BIT];

  // plain read/write words and poll pulses
  logic [DW-1:0] mii_dat_q, mii_adr_q, fifo_q, maxf_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      mii_dat_q <= '0;
      mii_adr_q <= RST_MII_ADR;
      fifo_q    <= RST_FIFO_TH;
      maxf_q    <= RST_MAX_FR;
      tx_poll   <= 1'b0;
      rx_poll   <= 1'b0;
    end else begin
      if (hit_miid) mii_dat_q <= bus_wdata;
      if (hit_miia) mii_adr_q <= bus_wdata;
      if (hit_fifo) fifo_q    <= bus_wdata;
      if (hit_maxf) maxf_q    <= bus_wdata;
      tx_poll <= hit_txp;
      rx_poll <= hit_rxp;
    end
  end

  assign fifo_thresh = fifo_q;
  assign max_frame   = maxf_q;

  // per-direction status, enable, interrupt and pointers
  logic [NDIR-1:0][HW-1:0] st_half, en_half, evt_half;
  logic [NDIR-1:0]         irq_vec, base_we, reload, dma_we, on_bit;
  logic [NDIR-1:0][DW-1:0] base_v, cur_v, dma_val;
  logic                    lock;

  assign evt_half[0] = rx_evt;
  assign evt_half[1] = tx_evt;
  assign base_we[0]  = hit_rxb;
  assign base_we[1]  = hit_txb;
  assign dma_we[0]   = rx_cur_we;
  assign dma_we[1]   = tx_cur_we;
  assign dma_val[0]  = rx_cur_val;
  assign dma_val[1]  = tx_cur_val;
  assign on_bit[0]   = bus_wdata[RXON_BIT] && !ctrl_q[RXON_BIT];
  assign on_bit[1]   = bus_wdata[TXON_BIT] && !ctrl_q[TXON_BIT];
  assign lock        = ctrl_q[TXON_BIT] | ctrl_q[RXON_BIT];

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    assign reload[g] = ctrl_wr && on_bit[g];

    mac_csr_irq_half #(
      .W    (HW),
      .IMPL (STAT_IMPL[g*HW +: HW]),
      .ENM  (EN_IMPL[g*HW +: HW])
    ) u_half (
      .clk      (clk),
      .clr      (clr),
      .st_we    (hit_st),
      .st_wdata (bus_wdata[g*HW +: HW]),
      .en_we    (hit_en),
      .en_wdata (bus_wdata[g*HW +: HW]),
      .evt      (evt_half[g]),
      .status   (st_half[g]),
      .enable   (en_half[g]),
      .irq      (irq_vec[g])
    );

    mac_csr_ptr #(
      .W        (DW),
      .BASE_RST (RST_LIST_BASE)
    ) u_ptr (
      .clk        (clk),
      .clr        (clr),
      .base_we    (base_we[g]),
      .base_wdata (bus_wdata),
      .lock       (lock),
      .reload     (reload[g]),
      .dma_we     (dma_we[g]),
      .dma_val    (dma_val[g]),
      .base       (base_v[g]),
      .cur        (cur_v[g])
    );
  end

  logic [DW-1:0] en_word, st_word;
  assign en_word = {en_half[1], en_half[0]};
  assign st_word = {st_half[1], st_half[0]};

  assign rx_irq       = irq_vec[0];
  assign tx_irq       = irq_vec[1];
  assign rx_list_base = base_v[0];
  assign tx_list_base = base_v[1];
  assign rx_cur_ptr   = cur_v[0];
  assign tx_cur_ptr   = cur_v[1];

  // read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_TX_BASE): rd_mux = base_v[1];
      ADDR_W'(OFS_RX_BASE): rd_mux = base_v[0];
      ADDR_W'(OFS_CTRL):    rd_mux = ctrl_q;
      ADDR_W'(OFS_MII_DAT): rd_mux = mii_dat_q;
      ADDR_W'(OFS_MII_ADR): rd_mux = mii_adr_q;
      ADDR_W'(OFS_FIFO_TH): rd_mux = fifo_q;
      ADDR_W'(OFS_MAX_FR):  rd_mux = maxf_q;
      ADDR_W'(OFS_INT_EN):  rd_mux = en_word;
      ADDR_W'(OFS_INT_ST):  rd_mux = st_word;
      ADDR_W'(OFS_MISSED):  rd_mux = RST_MISSED;
      ADDR_W'(OFS_TX_CUR):  rd_mux = cur_v[1];
      ADDR_W'(OFS_RX_CUR):  rd_mux = cur_v[0];
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= swr_busy ? '0 : rd_mux;
  end
endmodule

// File: rtl/mac_csr_bank_chk.sv
module mac_csr_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        swr_busy,
  input logic        swr_done,
  input logic        tx_enable,
  input logic        rx_enable,
  input logic [31:0] tx_list_base,
  input logic [31:0] rx_list_base,
  input logic [31:0] tx_cur_ptr,
  input logic [31:0] rx_cur_ptr,
  input logic [31:0] en_word,
  input logic        tx_irq,
  input logic        rx_irq
);
  AST_READ_ZERO_IN_SWR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && swr_busy) |=> (bus_rdata == 32'h0)); // R3

  AST_SWR_RESTORES: assert property (@(posedge clk) disable iff (rst)
    $fell(swr_busy) |-> (tx_list_base == 32'hFFFF_FFFC && rx_list_base == 32'hFFFF_FFFC
                         && !tx_enable && !rx_enable)); // R4

  AST_TX_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> ($past(en_word[31:16]) != 16'h0)); // R7

  AST_RX_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> ($past(en_word[15:0]) != 16'h0)); // R8

  AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    ((tx_enable || rx_enable) && !swr_done) |=> ($stable(tx_list_base) && $stable(rx_list_base))); // R10

  AST_TX_CUR_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_enable) |-> (tx_cur_ptr == tx_list_base)); // R11

  AST_RX_CUR_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_enable) |-> (rx_cur_ptr == rx_list_base)); // R11
endmodule

bind mac_csr_bank mac_csr_bank_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .swr_busy     (swr_busy),
  .swr_done     (swr_done),
  .tx_enable    (tx_enable),
  .rx_enable    (rx_enable),
  .tx_list_base (tx_list_base),
  .rx_list_base (rx_list_base),
  .tx_cur_ptr   (tx_cur_ptr),
  .rx_cur_ptr   (rx_cur_ptr),
  .en_word      (en_word),
  .tx_irq       (tx_irq),
  .rx_irq       (rx_irq)
);

// File: tb/mac_csr_bank_bench.sv
`timescale 1ns/1ps
module mac_csr_bank_bench;
  localparam int AW   = 7;
  localparam int SWRC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [15:0]   tx_evt = '0, rx_evt = '0;
  logic          tx_cur_we = 1'b0, rx_cur_we = 1'b0;
  logic [31:0]   tx_cur_val = '0, rx_cur_val = '0;
  logic          tx_enable, rx_enable, long_frame_ok;
  logic [31:0]   tx_list_base, rx_list_base, tx_cur_ptr, rx_cur_ptr;
  logic [31:0]   fifo_thresh, max_frame;
  logic          tx_poll, rx_poll, swr_busy, tx_irq, rx_irq;

  always #2.5 clk = ~clk;

  mac_csr_bank #(.ADDR_W(AW), .SWR_CYCLES(SWRC)) u_mac_csr_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .tx_cur_we(tx_cur_we), .tx_cur_val(tx_cur_val), .rx_cur_we(rx_cur_we),
    .rx_cur_val(rx_cur_val), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .long_frame_ok(long_frame_ok), .tx_list_base(tx_list_base),
    .rx_list_base(rx_list_base), .tx_cur_ptr(tx_cur_ptr), .rx_cur_ptr(rx_cur_ptr),
    .fifo_thresh(fifo_thresh), .max_frame(max_frame), .tx_poll(tx_poll),
    .rx_poll(rx_poll), .swr_busy(swr_busy), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int checks = 0;
  int failures = 0;

  // scoreboard queues
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic        rd_d = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: compares registered read data against the expected queue
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R13 unexpected read data actual=0x%08h expected=none", bus_rdata);
      end else begin
        check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issues a read and pushes the expected word
  task automatic bus_read(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [15:0] t, input logic [15:0] r);
    @(negedge clk);
    tx_evt = t; rx_evt = r;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int busy_cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset contents
    bus_read('h22, 32'hFFFF_FFFC, "R1 tx list start");
    bus_read('h23, 32'hFFFF_FFFC, "R1 rx list start");
    bus_read('h24, 32'h0, "R1 control");
    bus_read('h26, 32'h0090_0000, "R1 mii addr");
    bus_read('h27, 32'h0000_0101, "R1 fifo threshold");
    bus_read('h2A, 32'h0000_0800, "R1 max frame");
    bus_read('h2B, 32'h0, "R1 int enable");
    bus_read('h2C, 32'h0, "R1 int status");
    bus_read('h2E, 32'h0000_7FFF, "R1 missed counter");
    bus_read('h33, 32'h0, "R1 tx cur ptr");
    bus_read('h00, 32'h0, "R1 unmapped word");

    // R2 control masking and plain words
    bus_write('h24, 32'hFEFF_FFFF);
    bus_read('h24, 32'h0000_0103, "R2 control readback");
    check("R2 long_frame_ok port", {31'd0, long_frame_ok}, 32'd1);
    bus_write('h24, 32'h0);
    bus_write('h25, 32'hA5A5_1234);
    bus_read('h25, 32'hA5A5_1234, "R2 mii data readback");
    bus_write('h2A, 32'h0000_05F0);
    check("R2 max_frame port", max_frame, 32'h0000_05F0);

    // R9 enable masking
    bus_write('h2B, 32'hFFFF_FFFF);
    bus_read('h2B, 32'h0005_0011, "R9 enable mask");
    bus_write('h2B, 32'h0);

    // R5 event set and unimplemented bits
    pulse_evt(16'hFFFF, 16'h0);
    bus_read('h2C, 32'h0185_0000, "R5 tx events");
    pulse_evt(16'h0, 16'hFFFF);
    bus_read('h2C, 32'h0185_0F19, "R5 rx events");

    // R6 write-one-to-clear by half
    bus_write('h2C, 32'hFFFF_0000);
    bus_read('h2C, 32'h0000_0F19, "R6 clear tx half only");
    bus_write('h2C, 32'h0000_FFFF);
    bus_read('h2C, 32'h0, "R6 clear rx half");

    // R8 receive irq: only bit 4 enabled, tx enables set too
    bus_write('h2B, 32'h0004_0010);
    pulse_evt(16'h0, 16'h0008);
    @(negedge clk);
    check("R8 rx_irq ignores disabled bit", {31'd0, rx_irq}, 32'd0);
    pulse_evt(16'h0, 16'h0010);
    check("R8 rx_irq one cycle later", {31'd0, rx_irq}, 32'd0);
    @(negedge clk);
    check("R8 rx_irq raised", {31'd0, rx_irq}, 32'd1);
    check("R7 tx_irq quiet on rx event", {31'd0, tx_irq}, 32'd0);
    bus_write('h2C, 32'h0000_0010);
    check("R8 rx_irq still registered", {31'd0, rx_irq}, 32'd1);
    @(negedge clk);
    check("R8 rx_irq dropped", {31'd0, rx_irq}, 32'd0);
    bus_write('h2C, 32'h0000_FFFF);

    // R7 transmit irq from bit 18
    pulse_evt(16'h0004, 16'h0);
    check("R7 tx_irq one cycle later", {31'd0, tx_irq}, 32'd0);
    @(negedge clk);
    check("R7 tx_irq raised", {31'd0, tx_irq}, 32'd1);
    check("R8 rx_irq quiet on tx event", {31'd0, rx_irq}, 32'd0);
    bus_write('h2C, 32'hFFFF_0000);
    @(negedge clk);
    check("R7 tx_irq dropped", {31'd0, tx_irq}, 32'd0);

    // R12 poll pulses
    bus_write('h28, 32'h1);
    check("R12 tx_poll pulse", {30'd0, tx_poll, rx_poll}, 32'd2);
    @(negedge clk);
    check("R12 tx_poll one cycle", {31'd0, tx_poll}, 32'd0);
    bus_write('h29, 32'h1);
    check("R12 rx_poll pulse", {30'd0, tx_poll, rx_poll}, 32'd1);
    bus_read('h28, 32'h0, "R12 poll word reads zero");

    // R10 list start lock and alignment
    bus_write('h22, 32'h0000_2003);
    bus_read('h22, 32'h0000_2000, "R10 aligned write");
    bus_write('h23, 32'h0000_4000);
    bus_write('h24, 32'h0000_0001);
    bus_write('h22, 32'h0000_9000);
    bus_read('h22, 32'h0000_2000, "R10 locked by rx on");
    // R11 rx reload
    bus_read('h35, 32'h0000_4000, "R11 rx cur reloaded");
    bus_write('h24, 32'h0);
    bus_write('h22, 32'h0000_3000);
    bus_read('h22, 32'h0000_3000, "R10 unlocked");

    // R11 tx reload and DMA load
    bus_write('h24, 32'h0000_0100);
    check("R11 tx_cur_ptr port", tx_cur_ptr, 32'h0000_3000);
    @(negedge clk);
    tx_cur_we = 1'b1; tx_cur_val = 32'h0000_3010;
    @(negedge clk);
    tx_cur_we = 1'b0;
    bus_read('h33, 32'h0000_3010, "R11 dma load");
    bus_write('h24, 32'h0000_0100);
    bus_read('h33, 32'h0000_3010, "R11 no reload while on");

    // R3 / R4 software reset
    bus_write('h25, 32'h1234_5678);
    bus_write('h24, 32'h0100_0000);
    busy_cnt = 0;
    bus_read('h27, 32'h0, "R3 read during reset");
    bus_read('h2E, 32'h0, "R3 read during reset");
    bus_read('h25, 32'h0, "R3 read during reset");
    for (int i = 0; i < 40 && swr_busy; i++) begin
      busy_cnt = busy_cnt + 1;
      @(negedge clk);
    end
    busy_cnt = busy_cnt + 6;
    check("R3 busy length", busy_cnt, SWRC);
    bus_read('h24, 32'h0, "R4 control bit 24 clear");
    bus_read('h25, 32'h0, "R4 mii data restored");
    bus_read('h27, 32'h0000_0101, "R4 fifo threshold restored");
    bus_read('h22, 32'hFFFF_FFFC, "R4 tx list start restored");
    bus_read('h33, 32'h0, "R4 tx cur restored");
    check("R4 tx_enable off", {31'd0, tx_enable}, 32'd0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL R13 reads pending actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule